// File: doc/BRIEF.md
# Crossword CRC-Parity Erasure Codec

The block protects six 16-bit audio samples with a two-dimensional code. The samples form two data groups of three, A and B. A third group, P, holds the bitwise XOR of the matching A and B samples. Each group of three samples gets its own 16-bit CRC, which gives three 64-bit codewords and one 192-bit triple. The encoder path builds that triple.

The decoder path takes a received triple and checks every codeword against its CRC. A failing codeword is treated as an erasure: all three of its samples are taken as zero. If exactly one data group is erased, it is rebuilt from the other data group and the parity group. If only the parity group fails, the data goes through untouched. When two or more groups fail, no repair is tried, and the erased lanes are flagged as lost.

Both paths are valid/ready streams. A word moves on an edge where valid and ready are both high. A producer must hold valid and data steady until that edge. The pipelines stall when their outputs are not taken, and they never drop a word.

Top module: `xw_crossword_codec`

## Requirements
- R1: A codeword is 64 bits. Sample k of a group sits at bits [16k+15:16k], for k = 0..2. The CRC sits at bits [63:48]. The CRC uses the polynomial 0x1021 (x^16+x^12+x^5+1), starts from zero, and takes data bits 47 down to 0 one at a time, highest bit first.
- R2: Encoder input samples 0..2 (bits [47:0]) form group A and samples 3..5 form group B. In the triple, A is at [63:0], B at [127:64] and P at [191:128]. The data field of P is the XOR of A and B, and P carries its own CRC. The encoder output appears one clock after acceptance.
- R3: When all three codewords pass, the decoder outputs A in data bits [47:0] and B in [95:48], with every flag low.
- R4: When only the parity codeword fails, the data samples are output unchanged and no flag is set.
- R5: When exactly one data codeword fails, its three samples are replaced by the XOR of the other data group and P. Its three corrected flags are set: out_fixed[2:0] for A, out_fixed[5:3] for B.
- R6: When two or more codewords fail, nothing is corrected. Each failing data group is output as zero with its three bad flags set (out_bad[2:0] for A, [5:3] for B). A passing data group is output unchanged and unflagged.
- R7: With out_ready held high, a triple accepted on one edge is presented on the decoder output after the second edge from that one. Each accepted triple yields exactly one result.
- R8: While out_valid is high and out_ready is low, the output word and flags of that path hold steady. A stalled decoder lowers dec_in_ready once both of its stages are full, and it loses no triple.
- R9: While rst_n is low, both out_valid pins are low and both in_ready pins are high.
- R10: No lane is ever flagged corrected and bad at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_in_valid | input | 1 | Six samples offered to the encoder |
| enc_in_ready | output | 1 | Encoder can accept |
| enc_in_data | input | 96 | Samples 0..5, sample i at [16i+15:16i] |
| enc_out_valid | output | 1 | Encoded triple available |
| enc_out_ready | input | 1 | Consumer takes encoded triple |
| enc_out_word | output | 192 | Triple: A, B, P codewords from low to high |
| dec_in_valid | input | 1 | Received triple offered |
| dec_in_ready | output | 1 | Decoder can accept |
| dec_in_word | input | 192 | Received triple, same layout as enc_out_word |
| dec_out_valid | output | 1 | Decoded samples available |
| dec_out_ready | input | 1 | Consumer takes decoded samples |
| dec_out_data | output | 96 | Recovered samples, same layout as enc_in_data |
| dec_out_fixed | output | 6 | Per-sample corrected flag |
| dec_out_bad | output | 6 | Per-sample uncorrectable flag |

## Verification
The bench builds the block with its default parameters: 16-bit samples, three per group, and the 0x1021 polynomial. At that size each vector goes through the whole encode, corrupt and decode loop, and its expected values are worked out by hand-written reference functions. The vectors cover seven of the eight failure masks, including flips that land only in the CRC field and an all-ones pattern. A stalled sequence of three triples exercises the full-pipeline stall and the result order. A reset with a result still waiting confirms that the output is cleared.

// File: rtl/xw_pkg.sv
`timescale 1ns/1ps
package xw_pkg;
  typedef enum logic [1:0] {
    VD_CLEAN = 2'd0,
    VD_FIX_A = 2'd1,
    VD_FIX_B = 2'd2,
    VD_LOST  = 2'd3
  } xw_verdict_e;

  // fail[0]=A, fail[1]=B, fail[2]=parity group
  function automatic xw_verdict_e xw_classify(input logic [2:0] fail);
    case (fail)
      3'b000, 3'b100: return VD_CLEAN;
      3'b001:         return VD_FIX_A;
      3'b010:         return VD_FIX_B;
      default:        return VD_LOST;
    endcase
  endfunction
endpackage

// File: rtl/xw_crc.sv
`timescale 1ns/1ps
module xw_crc #(
  parameter int DATA_W = 48,
  parameter int CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  // serial division, highest data bit first, register starts at zero
  always_comb begin
    logic [CRC_W-1:0] rem;
    logic fb;
    rem = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb  = data_i[i] ^ rem[CRC_W-1];
      rem = {rem[CRC_W-2:0], 1'b0};
      if (fb) rem = rem ^ POLY;
    end
    crc_o = rem;
  end
endmodule

// File: rtl/xw_encoder.sv
`timescale 1ns/1ps
module xw_encoder #(
  parameter int SAMPLE_W = 16,
  parameter int LANES    = 3,
  parameter int CRC_W    = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      in_valid,
  output logic                                      in_ready,
  input  logic [2*SAMPLE_W*LANES-1:0]               in_data,
  output logic                                      out_valid,
  input  logic                                      out_ready,
  output logic [3*(SAMPLE_W*LANES+CRC_W)-1:0]       out_word
);
  localparam int DATA_W = SAMPLE_W * LANES;
  localparam int CW_W   = DATA_W + CRC_W;

  logic              vld_q;
  logic [DATA_W-1:0] grp_q [2];

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= 1'b0;
    else if (in_ready) vld_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      grp_q[0] <= in_data[DATA_W-1:0];
      grp_q[1] <= in_data[2*DATA_W-1:DATA_W];
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_cw
    logic [DATA_W-1:0] body;
    logic [CRC_W-1:0]  chk;
    if (g == 2) begin : g_par
      assign body = grp_q[0] ^ grp_q[1];
    end else begin : g_dat
      assign body = grp_q[g];
    end
    xw_crc #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(CRC_POLY)) crc_i (
      .data_i(body), .crc_o(chk));
    assign out_word[g*CW_W +: CW_W] = {chk, body};
  end

  // R8: encoder output is held while stalled
  assert_enc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word));
endmodule

// File: rtl/xw_decoder.sv
`timescale 1ns/1ps
module xw_decoder
  import xw_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int LANES    = 3,
  parameter int CRC_W    = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                in_valid,
  output logic                                in_ready,
  input  logic [3*(SAMPLE_W*LANES+CRC_W)-1:0] in_word,
  output logic                                out_valid,
  input  logic                                out_ready,
  output logic [2*SAMPLE_W*LANES-1:0]         out_data,
  output logic [2*LANES-1:0]                  out_fixed,
  output logic [2*LANES-1:0]                  out_bad
);
  localparam int DATA_W = SAMPLE_W * LANES;
  localparam int CW_W   = DATA_W + CRC_W;

  logic              s1_vld, s2_vld, s1_adv, s2_adv;
  logic [2:0]        fail_c, s1_fail;
  logic [DATA_W-1:0] s1_body [3];
  logic [DATA_W-1:0] masked [3];
  logic [DATA_W-1:0] rec_a, rec_b;
  logic [2*LANES-1:0] fix_c, bad_c;
  xw_verdict_e       verdict;

  assign s2_adv    = !s2_vld || out_ready;
  assign s1_adv    = !s1_vld || s2_adv;
  assign in_ready  = s1_adv;
  assign out_valid = s2_vld;

  // stage 1: CRC check of each received codeword
  for (genvar g = 0; g < 3; g++) begin : g_chk
    logic [CRC_W-1:0] calc;
    xw_crc #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(CRC_POLY)) crc_i (
      .data_i(in_word[g*CW_W +: DATA_W]), .crc_o(calc));
    assign fail_c[g] = calc != in_word[g*CW_W + DATA_W +: CRC_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s2_vld <= 1'b0;
    end else begin
      if (s1_adv) s1_vld <= in_valid;
      if (s2_adv) s2_vld <= s1_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && s1_adv) begin
      s1_fail <= fail_c;
      for (int g = 0; g < 3; g++) s1_body[g] <= in_word[g*CW_W +: DATA_W];
    end
  end

  // stage 2: erasure recovery by column parity
  always_comb begin
    for (int g = 0; g < 3; g++) masked[g] = s1_fail[g] ? '0 : s1_body[g];
    verdict = xw_classify(s1_fail);
    rec_a = masked[0];
    rec_b = masked[1];
    fix_c = '0;
    bad_c = '0;
    case (verdict)
      VD_FIX_A: begin
        rec_a = masked[1] ^ masked[2];
        fix_c[LANES-1:0] = '1;
      end
      VD_FIX_B: begin
        rec_b = masked[0] ^ masked[2];
        fix_c[2*LANES-1:LANES] = '1;
      end
      VD_LOST: bad_c = {{LANES{s1_fail[1]}}, {LANES{s1_fail[0]}}};
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (s1_vld && s2_adv) begin
      out_data  <= {rec_b, rec_a};
      out_fixed <= fix_c;
      out_bad   <= bad_c;
    end
  end

  // R8: decoder result is held while stalled
  assert_dec_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)
      && $stable(out_fixed) && $stable(out_bad));

  // R7: accepted triple is presented two edges later when unstalled
  assert_dec_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && out_ready) ##1 out_ready |=> out_valid);

  // R10: a lane is never corrected and lost together
  assert_flag_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_fixed & out_bad) == '0);

  // R5: corrections come as a whole group of lanes
  assert_fix_group_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_fixed) == 0 || $countones(out_fixed) == LANES));

  // R6: a lost lane carries zero
  for (genvar l = 0; l < 2*LANES; l++) begin : g_lost_chk
    assert_lost_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_bad[l] |-> out_data[l*SAMPLE_W +: SAMPLE_W] == '0);
  end
endmodule

// File: rtl/xw_crossword_codec.sv
`timescale 1ns/1ps
module xw_crossword_codec #(
  parameter int SAMPLE_W = 16,
  parameter int LANES    = 3,
  parameter int CRC_W    = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                enc_in_valid,
  output logic                                enc_in_ready,
  input  logic [2*SAMPLE_W*LANES-1:0]         enc_in_data,
  output logic                                enc_out_valid,
  input  logic                                enc_out_ready,
  output logic [3*(SAMPLE_W*LANES+CRC_W)-1:0] enc_out_word,
  input  logic                                dec_in_valid,
  output logic                                dec_in_ready,
  input  logic [3*(SAMPLE_W*LANES+CRC_W)-1:0] dec_in_word,
  output logic                                dec_out_valid,
  input  logic                                dec_out_ready,
  output logic [2*SAMPLE_W*LANES-1:0]         dec_out_data,
  output logic [2*LANES-1:0]                  dec_out_fixed,
  output logic [2*LANES-1:0]                  dec_out_bad
);
  xw_encoder #(.SAMPLE_W(SAMPLE_W), .LANES(LANES), .CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) enc_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(enc_in_valid), .in_ready(enc_in_ready), .in_data(enc_in_data),
    .out_valid(enc_out_valid), .out_ready(enc_out_ready), .out_word(enc_out_word));

  xw_decoder #(.SAMPLE_W(SAMPLE_W), .LANES(LANES), .CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) dec_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(dec_in_valid), .in_ready(dec_in_ready), .in_word(dec_in_word),
    .out_valid(dec_out_valid), .out_ready(dec_out_ready), .out_data(dec_out_data),
    .out_fixed(dec_out_fixed), .out_bad(dec_out_bad));

  // R9: no stale output out of reset
  assert_reset_idle_R9: assert property (@(posedge clk)
    !rst_n |=> !enc_out_valid && !dec_out_valid);
endmodule

// File: tb/xw_crossword_codec_tb.sv
`timescale 1ns/1ps
module xw_crossword_codec_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         enc_in_valid = 1'b0, enc_out_ready = 1'b1;
  logic [95:0]  enc_in_data = '0;
  logic         enc_in_ready, enc_out_valid;
  logic [191:0] enc_out_word;
  logic         dec_in_valid = 1'b0, dec_out_ready = 1'b1;
  logic [191:0] dec_in_word = '0;
  logic         dec_in_ready, dec_out_valid;
  logic [95:0]  dec_out_data;
  logic [5:0]   dec_out_fixed, dec_out_bad;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  xw_crossword_codec dut_i (.*);

  localparam logic [95:0] VEC_DATA [8] = '{
    96'h1234_5678_9ABC_DEF0_0F1E_2D3C, 96'hFFFF_0000_A5A5_5A5A_8001_7FFE,
    96'h0000_0000_0000_0000_0000_0001, 96'hC0DE_BEEF_F00D_CAFE_1357_2468,
    96'h7FFF_8000_0001_FFFE_4321_8765, 96'h0F0F_F0F0_3333_CCCC_5555_AAAA,
    96'h9999_6666_1111_EEEE_2222_DDDD, 96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF};
  // bit g: corrupt codeword g (0=A, 1=B, 2=P)
  localparam logic [2:0] VEC_HIT [8] = '{3'b000, 3'b100, 3'b001, 3'b010,
                                         3'b011, 3'b101, 3'b111, 3'b001};
  localparam int VEC_FLIP [8] = '{20, 37, 5, 55, 47, 0, 63, 12};

  function automatic logic [15:0] bcrc(input logic [47:0] d);
    logic [15:0] r = '0;
    for (int i = 47; i >= 0; i--) begin
      logic fb = d[i] ^ r[15];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  function automatic logic [191:0] benc(input logic [95:0] d);
    logic [47:0] a = d[47:0], b = d[95:48], p = d[47:0] ^ d[95:48];
    return {bcrc(p), p, bcrc(b), b, bcrc(a), a};
  endfunction

  task automatic bdec(input logic [191:0] w, output logic [95:0] d,
                      output logic [5:0] fx, output logic [5:0] bd);
    logic [2:0]  f;
    logic [47:0] b [3];
    for (int g = 0; g < 3; g++) begin
      b[g] = w[g*64 +: 48];
      f[g] = bcrc(b[g]) != w[g*64+48 +: 16];
      if (f[g]) b[g] = '0;
    end
    d = {b[1], b[0]}; fx = '0; bd = '0;
    if (f == 3'b001) begin d[47:0] = b[1] ^ b[2]; fx = 6'b000111; end
    else if (f == 3'b010) begin d[95:48] = b[0] ^ b[2]; fx = 6'b111000; end
    else if ($countones(f) >= 2) bd = {{3{f[1]}}, {3{f[0]}}};
  endtask

  task automatic chk(input bit ok, input string tag,
                     input logic [191:0] act, input logic [191:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_dec(input logic [191:0] w, input string tag);
    logic [95:0] ed; logic [5:0] ef, eb;
    bdec(w, ed, ef, eb);
    chk(dec_out_valid === 1'b1, {tag, " valid"}, 192'(dec_out_valid), 192'd1);
    chk({dec_out_data, dec_out_fixed, dec_out_bad} === {ed, ef, eb}, tag,
        192'({dec_out_data, dec_out_fixed, dec_out_bad}), 192'({ed, ef, eb}));
  endtask

  function automatic string vec_tag(input logic [2:0] h);
    if (h == 3'b000) return "R3 clean";
    if (h == 3'b100) return "R4 parity-only";
    if (h == 3'b001 || h == 3'b010) return "R5 single data erasure";
    return "R6 multiple erasures";
  endfunction

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [191:0] w, t1, t2, t3;
    // R9: reset state
    repeat (3) @(negedge clk);
    chk(!enc_out_valid && !dec_out_valid && enc_in_ready && dec_in_ready,
        "R9 reset idle", 192'({enc_out_valid, dec_out_valid, enc_in_ready, dec_in_ready}), 192'b0011);
    rst_n = 1'b1;

    // vector table: encode, corrupt, decode
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      enc_in_valid = 1'b1; enc_in_data = VEC_DATA[i];
      @(negedge clk);
      enc_in_valid = 1'b0;
      chk(enc_out_valid && enc_out_word === benc(VEC_DATA[i]), "R1 R2 encode",
          enc_out_word, benc(VEC_DATA[i]));
      w = enc_out_word;
      for (int g = 0; g < 3; g++)
        if (VEC_HIT[i][g]) w[g*64 + VEC_FLIP[i]] = ~w[g*64 + VEC_FLIP[i]];
      dec_in_valid = 1'b1; dec_in_word = w;
      @(negedge clk);
      dec_in_valid = 1'b0;
      chk(!dec_out_valid, "R7 not early", 192'(dec_out_valid), 192'd0);
      @(negedge clk);
      chk_dec(w, vec_tag(VEC_HIT[i]));
      @(negedge clk);
      chk(!dec_out_valid, "R7 single result", 192'(dec_out_valid), 192'd0);
    end

    // R8: stall with three triples in flight
    t1 = benc(VEC_DATA[3]); t1[40] = ~t1[40];
    t2 = benc(VEC_DATA[0]);
    t3 = benc(VEC_DATA[5]); t3[64+9] = ~t3[64+9];
    dec_out_ready = 1'b0;
    dec_in_valid = 1'b1; dec_in_word = t1;
    @(negedge clk); dec_in_word = t2;
    @(negedge clk); dec_in_word = t3;
    chk(!dec_in_ready, "R8 full pipeline stalls input", 192'(dec_in_ready), 192'd0);
    chk_dec(t1, "R8 stalled head");
    repeat (3) @(negedge clk);
    chk_dec(t1, "R8 held while stalled");
    dec_out_ready = 1'b1;
    @(negedge clk);
    dec_in_valid = 1'b0;
    chk_dec(t2, "R8 second in order");
    @(negedge clk);
    chk_dec(t3, "R8 third in order");
    @(negedge clk);
    chk(!dec_out_valid, "R8 drained", 192'(dec_out_valid), 192'd0);

    // R9: reset clears a waiting result
    dec_out_ready = 1'b0;
    dec_in_valid = 1'b1; dec_in_word = t2;
    @(negedge clk); dec_in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(dec_out_valid, "R9 result waiting", 192'(dec_out_valid), 192'd1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!dec_out_valid && dec_in_ready, "R9 reset clears",
        192'({dec_out_valid, dec_in_ready}), 192'b01);
    rst_n = 1'b1; dec_out_ready = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule